// File: doc/BRIEF.md
# Polled Byte Transfer Engine (Host Side)

This block runs the host end of a four-port polled handshake with a slow peripheral, so no processor has to sit in a polling loop. A pulse on `go` makes it issue a start command on the command port and then raise its request status. It watches the peripheral's status port until that reports data ready, then takes the byte from the data port. The byte goes out on a one-cycle output stream together with its running count. The engine then signals that the byte was taken and waits for the peripheral to go back to idle before it asks for the next byte.

The transfer ends in one of three ways: an end-of-transmission byte (0x04), a byte-count limit of 1024, or a programmable watchdog that expires while the engine waits on the peripheral. At the end the engine issues the halt command, drops its status to quiet, and pulses `done` with a reason code. The peripheral status crosses from another clock domain. It passes through two flops, and a new value is only accepted once two consecutive synchronized samples agree.

States: IDLE, SEND_CMD, REQ, WAIT_RDY, TAKE, WAIT_IDLE, RELEASE, FINISH. Transitions:
- IDLE→SEND_CMD on `go`.
- SEND_CMD→REQ→WAIT_RDY unconditionally.
- WAIT_RDY→TAKE when the filtered status reads ready. WAIT_RDY→FINISH on watchdog expiry.
- TAKE→WAIT_IDLE unconditionally.
- WAIT_IDLE→RELEASE when the status reads idle and more bytes are wanted. WAIT_IDLE→FINISH when the status reads idle after the last byte, or on watchdog expiry.
- RELEASE→REQ unconditionally.
- FINISH→IDLE unconditionally.

Top module: `poll_xfer_engine`

## Requirements
- R1: After reset, `cmd_out` is 000, `host_stat` is 00, and `out_valid`, `done` and `err` are 0.
- R2: A `go` pulse in IDLE puts command 001 (start) on `cmd_out` one cycle before `host_stat` becomes 01 (request). `host_stat` is 01 only while `cmd_out` holds 001.
- R3: A peripheral status change is accepted only after two agreeing synchronized samples. A one-cycle pulse of `dev_stat` to 10 is ignored: no byte is taken and `host_stat` stays 01.
- R4: When the filtered peripheral status reads 10 (ready), the engine pulses `out_valid` for one cycle. On that cycle `out_byte` equals `dev_data`, `out_count` equals the 1-based number of bytes delivered so far, and `host_stat` is still 01.
- R5: In the cycle after `out_valid`, `host_stat` becomes 10 (taken). It holds 10 until the peripheral status is seen back at 00.
- R6: When the peripheral returns to 00 and more bytes are wanted, `host_stat` goes to 00 for exactly one cycle and then back to 01.
- R7: A delivered byte equal to 0x04 is the last one. Once the peripheral returns to 00, `done` pulses with `done_reason` 01. A byte of 0x00 or 0xFF does not end the transfer.
- R8: The 1024th delivered byte is the last one. `done` then pulses with `done_reason` 10, and `out_count` never exceeds 1024.
- R9: If the filtered peripheral status stays unchanged for `timeout_lim` cycles in WAIT_RDY or WAIT_IDLE, the engine finishes with `done_reason` 11 and sets `err`. `err` holds until the next accepted `go`, which clears it.
- R10: At every finish `done` is a single-cycle pulse, and on that cycle `cmd_out` is 010 (halt) and `host_stat` is 00.
- R11: A `go` pulse during a transfer is ignored: the command stays 001 and the byte count continues without restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse, accepted in IDLE only |
| timeout_lim | input | TMR_W | Watchdog limit in cycles |
| dev_stat | input | 2 | Peripheral status (00 idle, 01 busy, 10 ready), asynchronous |
| dev_data | input | DATA_W | Peripheral data port |
| cmd_out | output | 3 | Command port (001 start, 010 halt) |
| host_stat | output | 2 | Host status port (00 quiet, 01 request, 10 taken) |
| out_valid | output | 1 | One-cycle byte strobe |
| out_byte | output | DATA_W | Delivered byte |
| out_count | output | CNT_W | 1-based count of delivered bytes |
| done | output | 1 | One-cycle end-of-transfer pulse |
| done_reason | output | 2 | 01 end byte, 10 count limit, 11 timeout |
| err | output | 1 | Timeout abort flag |

## Verification
Each handshake step shows up on the ports within a few cycles of its cause, so a wrong state is quickly visible:
- A state that skips RELEASE shows as `host_stat` going from 10 straight to 01.
- A state that takes a byte too early shows as `out_valid` while `host_stat` is not 01, or as a glitch being accepted.
- A wrong end decision shows at the next idle return of the peripheral: `done` fires early or late, or `done_reason` is wrong.

A stuck wait state shows as a missing `done` after `timeout_lim` plus the filter latency.

// File: rtl/pxe_pkg.sv
package pxe_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_SEND_CMD, S_REQ, S_WAIT_RDY,
        S_TAKE, S_WAIT_IDLE, S_RELEASE, S_FINISH
    } pxe_state_t;

    localparam logic [2:0] CMD_NONE  = 3'b000;
    localparam logic [2:0] CMD_START = 3'b001;
    localparam logic [2:0] CMD_HALT  = 3'b010;

    localparam logic [1:0] HS_QUIET = 2'b00;
    localparam logic [1:0] HS_REQ   = 2'b01;
    localparam logic [1:0] HS_TAKEN = 2'b10;

    localparam logic [1:0] DS_IDLE  = 2'b00;
    localparam logic [1:0] DS_READY = 2'b10;

    localparam logic [1:0] WHY_NONE    = 2'b00;
    localparam logic [1:0] WHY_EOT     = 2'b01;
    localparam logic [1:0] WHY_LIMIT   = 2'b10;
    localparam logic [1:0] WHY_TIMEOUT = 2'b11;

    localparam int EOT_VALUE = 4;
endpackage

// File: rtl/pxe_status_sync.sv
module pxe_status_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q,
    output logic         chg
);
    logic [W-1:0] s1, s2, s2_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1   <= '0;
            s2   <= '0;
            s2_d <= '0;
            q    <= '0;
            chg  <= 1'b0;
        end else begin
            s1   <= d_in;
            s2   <= s1;
            s2_d <= s2;
            chg  <= 1'b0;
            if (s2 == s2_d && s2 != q) begin
                q   <= s2;
                chg <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pxe_wait_timer.sv
module pxe_wait_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [TMR_W-1:0] lim,
    output logic             expired
);
    logic [TMR_W-1:0] cnt;

    assign expired = run && (cnt >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || !run)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pxe_byte_tally.sv
module pxe_byte_tally #(
    parameter int MAX_BYTES = 1024,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             full
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_BYTES);

    assign full = (cnt == LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && !full)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/poll_xfer_engine.sv
module poll_xfer_engine
    import pxe_pkg::*;
#(
    parameter int MAX_BYTES = 1024,
    parameter int TMR_W     = 16,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [TMR_W-1:0]  timeout_lim,
    input  logic [1:0]        dev_stat,
    input  logic [DATA_W-1:0] dev_data,
    output logic [2:0]        cmd_out,
    output logic [1:0]        host_stat,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_byte,
    output logic [CNT_W-1:0]  out_count,
    output logic              done,
    output logic [1:0]        done_reason,
    output logic              err
);
    localparam logic [DATA_W-1:0] EOT_BYTE = DATA_W'(EOT_VALUE);

    pxe_state_t state, nxt;
    logic [1:0] filt;
    logic       filt_chg;
    logic       tmr_run, tmr_exp;
    logic       full;
    logic       last_q;
    logic [1:0] pend_q;
    logic       tmo_exit;

    pxe_status_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(dev_stat), .q(filt), .chg(filt_chg)
    );

    assign tmr_run = (state == S_WAIT_RDY) || (state == S_WAIT_IDLE);

    pxe_wait_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .restart(filt_chg),
        .lim(timeout_lim), .expired(tmr_exp)
    );

    pxe_byte_tally #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_tally (
        .clk(clk), .rst_n(rst_n), .clr(nxt == S_SEND_CMD),
        .inc(nxt == S_TAKE), .cnt(out_count), .full(full)
    );

    assign tmo_exit = ((state == S_WAIT_RDY)  && (filt != DS_READY)) ||
                      ((state == S_WAIT_IDLE) && (filt != DS_IDLE));

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:      if (go) nxt = S_SEND_CMD;
            S_SEND_CMD:  nxt = S_REQ;
            S_REQ:       nxt = S_WAIT_RDY;
            S_WAIT_RDY: begin
                if (filt == DS_READY)  nxt = S_TAKE;
                else if (tmr_exp)      nxt = S_FINISH;
            end
            S_TAKE:      nxt = S_WAIT_IDLE;
            S_WAIT_IDLE: begin
                if (filt == DS_IDLE)   nxt = last_q ? S_FINISH : S_RELEASE;
                else if (tmr_exp)      nxt = S_FINISH;
            end
            S_RELEASE:   nxt = S_REQ;
            S_FINISH:    nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_out     <= CMD_NONE;
            host_stat   <= HS_QUIET;
            out_valid   <= 1'b0;
            out_byte    <= '0;
            done        <= 1'b0;
            done_reason <= WHY_NONE;
            err         <= 1'b0;
            last_q      <= 1'b0;
            pend_q      <= WHY_NONE;
        end else begin
            out_valid <= (nxt == S_TAKE);
            done      <= (nxt == S_FINISH);
            unique case (nxt)
                S_REQ, S_WAIT_RDY, S_TAKE: host_stat <= HS_REQ;
                S_WAIT_IDLE:               host_stat <= HS_TAKEN;
                default:                   host_stat <= HS_QUIET;
            endcase
            if (nxt == S_TAKE)
                out_byte <= dev_data;
            if (nxt == S_SEND_CMD) begin
                cmd_out     <= CMD_START;
                err         <= 1'b0;
                done_reason <= WHY_NONE;
                last_q      <= 1'b0;
                pend_q      <= WHY_NONE;
            end
            if (state == S_TAKE) begin
                if (out_byte == EOT_BYTE) begin
                    last_q <= 1'b1;
                    pend_q <= WHY_EOT;
                end else if (full) begin
                    last_q <= 1'b1;
                    pend_q <= WHY_LIMIT;
                end
            end
            if (nxt == S_FINISH) begin
                cmd_out <= CMD_HALT;
                if (tmo_exit) begin
                    done_reason <= WHY_TIMEOUT;
                    err         <= 1'b1;
                end else begin
                    done_reason <= pend_q;
                end
            end
        end
    end
endmodule

// File: rtl/pxe_chk.sv
module pxe_chk #(
    parameter int MAX_BYTES = 1024,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cmd_out,
    input logic [1:0]       host_stat,
    input logic             out_valid,
    input logic [CNT_W-1:0] out_count,
    input logic             done,
    input logic [1:0]       done_reason,
    input logic             err
);
    // R2
    req_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stat == 2'b01) |-> (cmd_out == 3'b001));
    // R4
    take_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (host_stat == 2'b01));
    // R5
    ack_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (host_stat == 2'b10));
    // R6
    release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(host_stat) == 2'b10 && host_stat != 2'b10) |-> (host_stat == 2'b00));
    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_count <= CNT_W'(MAX_BYTES));
    // R9
    err_with_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (done && done_reason == 2'b11));
    // R10
    done_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd_out == 3'b010 && host_stat == 2'b00 && !out_valid));
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind poll_xfer_engine pxe_chk #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_out(cmd_out), .host_stat(host_stat),
    .out_valid(out_valid), .out_count(out_count), .done(done),
    .done_reason(done_reason), .err(err)
);

// File: tb/sim_poll_xfer_engine.sv
module sim_poll_xfer_engine;
    localparam int MAXB  = 1024;
    localparam int CNT_W = $clog2(MAXB + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             go = 1'b0;
    logic [15:0]      timeout_lim = 16'd300;
    logic [1:0]       dev_stat = 2'b00;
    logic [7:0]       dev_data = 8'h00;
    logic [2:0]       cmd_out;
    logic [1:0]       host_stat;
    logic             out_valid;
    logic [7:0]       out_byte;
    logic [CNT_W-1:0] out_count;
    logic             done;
    logic [1:0]       done_reason;
    logic             err;

    int vecs = 0;
    int fails = 0;

    always #4 clk = ~clk;

    poll_xfer_engine u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .timeout_lim(timeout_lim),
        .dev_stat(dev_stat), .dev_data(dev_data), .cmd_out(cmd_out),
        .host_stat(host_stat), .out_valid(out_valid), .out_byte(out_byte),
        .out_count(out_count), .done(done), .done_reason(done_reason), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic start_xfer;
        go = 1'b1;
        tick();
        go = 1'b0;
        chk(cmd_out == 3'b001, "R2 start command", cmd_out, 1);
        chk(host_stat == 2'b00, "R2 status before command", host_stat, 0);
        tick();
        chk(host_stat == 2'b01, "R2 request raised", host_stat, 1);
    endtask

    task automatic serve(input logic [7:0] b, input int exp_cnt, input bit last, input int why);
        int g;
        g = 0;
        while (host_stat != 2'b01 && g < 100) begin tick(); g++; end
        dev_data = b;
        dev_stat = 2'b10;
        g = 0;
        while (!out_valid && g < 30) begin tick(); g++; end
        chk(out_valid == 1'b1, "R4 byte strobe", out_valid, 1);
        chk(out_byte == b, "R4 byte value", out_byte, b);
        chk(out_count == CNT_W'(exp_cnt), "R4 byte count", out_count, exp_cnt);
        chk(host_stat == 2'b01, "R4 status at strobe", host_stat, 1);
        tick();
        chk(host_stat == 2'b10, "R5 taken status", host_stat, 2);
        repeat (3) tick();
        chk(host_stat == 2'b10, "R5 taken held", host_stat, 2);
        dev_stat = 2'b00;
        g = 0;
        while (host_stat == 2'b10 && g < 30) begin tick(); g++; end
        if (last) begin
            chk(done == 1'b1, "R10 done pulse", done, 1);
            chk(done_reason == 2'(why), "R7 R8 finish reason", done_reason, why);
            chk(cmd_out == 3'b010, "R10 halt command", cmd_out, 2);
            chk(host_stat == 2'b00, "R10 quiet status", host_stat, 0);
            tick();
            chk(done == 1'b0, "R10 single pulse", done, 0);
        end else begin
            chk(done == 1'b0, "R7 no early finish", done, 0);
            chk(host_stat == 2'b00, "R6 release quiet", host_stat, 0);
            tick();
            chk(host_stat == 2'b01, "R6 request again", host_stat, 1);
        end
    endtask

    task automatic t_reset;
        chk(cmd_out == 3'b000, "R1 cmd", cmd_out, 0);
        chk(host_stat == 2'b00, "R1 status", host_stat, 0);
        chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(err == 1'b0, "R1 err", err, 0);
    endtask

    task automatic t_eot;
        start_xfer();
        serve(8'h5A, 1, 1'b0, 0);
        serve(8'h00, 2, 1'b0, 0);
        serve(8'hFF, 3, 1'b0, 0);
        serve(8'h04, 4, 1'b1, 1);
        chk(err == 1'b0, "R7 no error", err, 0);
    endtask

    task automatic t_glitch;
        int seen;
        start_xfer();
        dev_data = 8'h33;
        dev_stat = 2'b10;
        tick();
        dev_stat = 2'b00;
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            tick();
            if (out_valid) seen++;
        end
        chk(seen == 0, "R3 glitch ignored", seen, 0);
        chk(host_stat == 2'b01, "R3 still requesting", host_stat, 1);
        serve(8'h04, 1, 1'b1, 1);
    endtask

    task automatic t_go_busy;
        start_xfer();
        serve(8'h11, 1, 1'b0, 0);
        go = 1'b1;
        tick();
        go = 1'b0;
        tick();
        chk(cmd_out == 3'b001, "R11 command unchanged", cmd_out, 1);
        chk(out_count == CNT_W'(1), "R11 count kept", out_count, 1);
        serve(8'h04, 2, 1'b1, 1);
    endtask

    task automatic t_timeout;
        int g;
        timeout_lim = 16'd40;
        start_xfer();
        g = 0;
        while (!done && g < 100) begin tick(); g++; end
        chk(done == 1'b1, "R9 timeout finish", done, 1);
        chk(done_reason == 2'b11, "R9 timeout reason", done_reason, 3);
        chk(err == 1'b1, "R9 err set", err, 1);
        chk(cmd_out == 3'b010, "R9 halt on abort", cmd_out, 2);
        chk(g >= 40, "R9 not before limit", g, 40);
        repeat (5) tick();
        chk(err == 1'b1, "R9 err held", err, 1);
        timeout_lim = 16'd300;
        start_xfer();
        chk(err == 1'b0, "R9 err cleared by go", err, 0);
        serve(8'h04, 1, 1'b1, 1);
    endtask

    task automatic t_limit;
        start_xfer();
        for (int i = 1; i <= MAXB; i++)
            serve(8'(16 + (i % 200)), i, (i == MAXB), 2);
        chk(out_count == CNT_W'(MAXB), "R8 final count", out_count, MAXB);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_eot();
        t_glitch();
        t_go_busy();
        t_timeout();
        t_limit();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule